// File: doc/BRIEF.md
# RTC status flags and alarm interrupt controller

This block keeps the sticky status flags of a real-time clock and the control bits that govern them. Five flags are held: an alarm match, a main-supply brownout, two battery-low levels, and a power-fail flag. The alarm, brownout and battery flags are set by one-cycle or level inputs from comparators outside the block. The power-fail flag is set only when power returns after both supplies were lost.

Software reaches the flags and a control byte through a simple strobe interface. Each access carries an address, a read/write select and write data. A separate STOP strobe marks the end of the bus transaction. The control byte selects three behaviours. The first makes the four clearable flags clear themselves once a status read is closed by a STOP. The second opens the time registers to writes. The third switches the active-low alarm request between a fixed-width pulse, timed on a 32.768 kHz tick, and a level that follows the alarm flag.

When a time-register write is accepted, counting halts. Counting restarts at the STOP that ends that write, and the one-second phase is realigned at the same STOP.

Top module: `rtc_flag_irq`

## Requirements
- R1: After reset, `flags` is 0, the control byte reads 0, `irq_n` is 1, and `count_run`, `sec_align` and `time_we` are 0.
- R2: `flags` bit 0 is the alarm flag, bit 1 brownout, bit 2 battery-low-85 and bit 3 battery-low-75. Each is set in the cycle after `alm_hit`, `vdd_low`, `bat_low85` or `bat_low75` respectively is sampled high.
- R3: A write to address 0 (status) clears each of flags bits 0..3 whose data bit is 0 and leaves bits written 1 unchanged. Flag bit 4 (power-fail) cannot be changed by such a write.
- R4: Control bit 7 is auto-clear. When it is 1, a read of address 0 followed by `acc_stop` clears flags bits 0..3 in the cycle after the STOP, while bit 4 is kept. A read of address 0 returns the flags on `rd_data` bits 4..0.
- R5: When control bit 7 is 0, a status read closed by STOP leaves every flag set.
- R6: When control bit 5 is 1 (pulse mode), `irq_n` goes low in the cycle after `alm_hit`. It returns high in the cycle after the PULSE_TICKS-th `tick` counted from then. An alarm arriving during the pulse does not lengthen it.
- R7: When control bit 5 is 0 (level mode), `irq_n` is the inverse of flags bit 0.
- R8: Flags bit 4 is set by `pwr_up` only when `lost_main` and `lost_batt` are both 1. Loss of one supply alone does not set it.
- R9: An accepted time write (address 2) clears flags bit 4. If a power-fail set arrives in the same cycle, the flag stays 1.
- R10: Control bit 6 enables time writes. While it is 0, a write to address 2 gives `time_we`=0 and changes neither flags bit 4 nor `count_run`.
- R11: An accepted time write drives `time_we` high in its own cycle and clears `count_run`. The next `acc_stop` sets `count_run` and pulses `sec_align` high for exactly one cycle.
- R12: When a hardware set and a clear event act on a flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 32.768 kHz |
| alm_hit | input | 1 | Alarm match event |
| vdd_low | input | 1 | Main supply below trip level |
| bat_low85 | input | 1 | Battery below the upper trip level |
| bat_low75 | input | 1 | Battery below the lower trip level |
| pwr_up | input | 1 | One-cycle power-up indication |
| lost_main | input | 1 | Main supply was absent before power-up |
| lost_batt | input | 1 | Battery supply was absent before power-up |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | 0 status, 1 control, 2 time section |
| acc_wdata | input | 8 | Write data |
| acc_stop | input | 1 | End of bus transaction |
| flags | output | 5 | Status flags {pf, bat75, bat85, vdd, alarm} |
| rd_data | output | 8 | Read data of the addressed register |
| irq_n | output | 1 | Active-low alarm request |
| time_we | output | 1 | Write strobe to the time registers |
| count_run | output | 1 | Time counters may count |
| sec_align | output | 1 | One-cycle realignment of the 1 Hz phase |

## Verification
A pending-read or pending-write state that is lost or left stuck shows up at the first STOP. Either the flags fail to clear, or `count_run` and `sec_align` stay low or fire when no write was accepted. A wrong pulse counter shows as an `irq_n` edge one tick early or late at the end of the pulse window, which is about 8192 ticks long. A wrong clear priority shows in the cycle right after the colliding event, as a missing flag bit.

// File: rtl/rtc_flag_irq.sv
module rtc_flag_irq #(
  parameter int PULSE_TICKS = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alm_hit,
  input  logic       vdd_low,
  input  logic       bat_low85,
  input  logic       bat_low75,
  input  logic       pwr_up,
  input  logic       lost_main,
  input  logic       lost_batt,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [1:0] acc_addr,
  input  logic [7:0] acc_wdata,
  input  logic       acc_stop,
  output logic [4:0] flags,
  output logic [7:0] rd_data,
  output logic       irq_n,
  output logic       time_we,
  output logic       count_run,
  output logic       sec_align
);
  localparam int CW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);
  localparam logic [1:0] A_STAT = 2'd0, A_CTRL = 2'd1, A_TIME = 2'd2;

  logic [7:0]    ctrl_q;
  logic          rd_pend, wr_pend, pulsing;
  logic [CW-1:0] pcnt;
  logic [3:0]    flag_nxt;

  wire arst     = ctrl_q[7];
  wire wrtc     = ctrl_q[6];
  wire pmode    = ctrl_q[5];
  wire wr_stat  = acc_valid & acc_write & (acc_addr == A_STAT);
  wire wr_ctrl  = acc_valid & acc_write & (acc_addr == A_CTRL);
  wire rd_stat  = acc_valid & ~acc_write & (acc_addr == A_STAT);
  wire pf_set   = pwr_up & lost_main & lost_batt;
  wire auto_clr = acc_stop & rd_pend & arst;
  wire [3:0] hw_set = {bat_low75, bat_low85, vdd_low, alm_hit};

  assign time_we = acc_valid & acc_write & (acc_addr == A_TIME) & wrtc;
  assign irq_n   = pmode ? ~pulsing : ~flags[0];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      flag_nxt[i] = flags[i];
      if (wr_stat)   flag_nxt[i] = flags[i] & acc_wdata[i];
      if (auto_clr)  flag_nxt[i] = 1'b0;
      if (hw_set[i]) flag_nxt[i] = 1'b1;
    end
  end

  always_comb begin
    case (acc_addr)
      A_STAT:  rd_data = {3'b000, flags};
      A_CTRL:  rd_data = ctrl_q;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      ctrl_q    <= '0;
      rd_pend   <= 1'b0;
      wr_pend   <= 1'b0;
      count_run <= 1'b0;
      sec_align <= 1'b0;
    end else begin
      flags[3:0] <= flag_nxt;
      if (pf_set)       flags[4] <= 1'b1;
      else if (time_we) flags[4] <= 1'b0;
      if (wr_ctrl) ctrl_q <= acc_wdata;
      if (acc_stop)     rd_pend <= 1'b0;
      else if (rd_stat) rd_pend <= 1'b1;
      if (acc_stop)     wr_pend <= 1'b0;
      else if (time_we) wr_pend <= 1'b1;
      if (time_we)                  count_run <= 1'b0;
      else if (acc_stop && wr_pend) count_run <= 1'b1;
      sec_align <= acc_stop & wr_pend & ~time_we;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulsing <= 1'b0;
      pcnt    <= '0;
    end else if (pulsing) begin
      if (tick) begin
        if (pcnt == LAST) begin
          pulsing <= 1'b0;
          pcnt    <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end else if (alm_hit) begin
      pulsing <= 1'b1;
      pcnt    <= '0;
    end
  end
endmodule

// File: rtl/rtc_flag_irq_chk.sv
module rtc_flag_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alm_hit,
  input logic       vdd_low,
  input logic       pwr_up,
  input logic       lost_main,
  input logic       lost_batt,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [1:0] acc_addr,
  input logic       acc_stop,
  input logic [4:0] flags,
  input logic [7:0] ctrl_q,
  input logic       rd_pend,
  input logic       pulsing,
  input logic       count_run
);
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stop && rd_pend && ctrl_q[7] && !vdd_low) |=> !flags[1]); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !ctrl_q[7] && !(acc_valid && acc_write && acc_addr == 2'd0)) |=> flags[1]); // R5

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulsing) |-> $past(alm_hit)); // R6

  AST_PF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(pwr_up && lost_main && lost_batt)); // R8

  AST_RUN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_run) |-> $past(acc_stop)); // R11

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> flags[0]); // R12
endmodule

bind rtc_flag_irq rtc_flag_irq_chk u_chk (.*);

// File: tb/test_rtc_flag_irq.sv
`timescale 1ns/1ps
module test_rtc_flag_irq;
  localparam int PT = 8192;
  logic clk = 0, rst_n = 0, tick = 0, alm_hit = 0, vdd_low = 0, bat_low85 = 0, bat_low75 = 0;
  logic pwr_up = 0, lost_main = 0, lost_batt = 0, acc_valid = 0, acc_write = 0, acc_stop = 0;
  logic [1:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic [4:0] flags;
  logic [7:0] rd_data;
  logic irq_n, time_we, count_run, sec_align;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rtc_flag_irq #(.PULSE_TICKS(PT)) i_rtc_flag_irq (.*);

  // {hw set[3:0], write mask[3:0], expected[3:0]}
  localparam logic [11:0] VEC [6] = '{
    12'b0001_1111_0001, 12'b1111_0000_0000, 12'b1010_1110_1010,
    12'b0110_0010_0010, 12'b1111_0101_0101, 12'b1100_1011_1000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic idle;
    acc_valid = 0; acc_write = 0; acc_stop = 0; alm_hit = 0; vdd_low = 0;
    bat_low85 = 0; bat_low75 = 0; pwr_up = 0; tick = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d; step; idle;
  endtask

  task automatic stop; acc_stop = 1; step; idle; endtask

  task automatic set_hw(input logic [3:0] s);
    {bat_low75, bat_low85, vdd_low, alm_hit} = s; step; idle;
  endtask

  task automatic give_ticks(input int n);
    for (int k = 0; k < n; k++) begin tick = 1; step; tick = 0; step; end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

  initial begin
    repeat (3) step;
    rst_n = 1; step;
    // R1 reset state
    check("R1 flags", flags, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 count_run", count_run, 0);
    check("R1 sec_align", sec_align, 0);
    acc_addr = 2'd1; #1 check("R1 ctrl", rd_data, 0);
    check("R1 time_we", time_we, 0);

    // R8 power-fail set only after both supplies lost
    pwr_up = 1; lost_main = 1; lost_batt = 0; step; idle;
    check("R8 one supply", flags[4], 0);
    pwr_up = 1; lost_batt = 1; step; idle; lost_main = 0; lost_batt = 0;
    check("R8 both lost", flags[4], 1);

    // R2/R3 vector walk
    foreach (VEC[v]) begin
      wr(2'd0, 8'h00);
      set_hw(VEC[v][11:8]);
      check("R2 hw set", flags[3:0], VEC[v][11:8]);
      wr(2'd0, {4'b0000, VEC[v][7:4]});
      check("R3 write clear", flags[3:0], VEC[v][3:0]);
    end
    check("R3 pf untouched by status write", flags[4], 1);

    // R10 time write blocked while enable is 0
    wr(2'd0, 8'h00);
    acc_valid = 1; acc_write = 1; acc_addr = 2'd2; acc_wdata = 8'h55;
    #1 check("R10 time_we blocked", time_we, 0);
    step; idle; stop;
    check("R10 count_run unchanged", count_run, 0);
    check("R10 pf unchanged", flags[4], 1);

    // R9/R11 accepted write
    wr(2'd1, 8'h40);
    acc_valid = 1; acc_write = 1; acc_addr = 2'd2; acc_wdata = 8'h12;
    #1 check("R11 time_we", time_we, 1);
    step; idle;
    check("R9 pf cleared", flags[4], 0);
    check("R11 halted", count_run, 0);
    stop;
    check("R11 run at stop", count_run, 1);
    check("R11 align pulse", sec_align, 1);
    step;
    check("R11 align one cycle", sec_align, 0);
    acc_valid = 1; acc_write = 1; acc_addr = 2'd2; pwr_up = 1; lost_main = 1; lost_batt = 1;
    step; idle; lost_main = 0; lost_batt = 0;
    check("R9 set wins", flags[4], 1);
    check("R11 halted again", count_run, 0);
    stop;

    // R4 auto-clear
    wr(2'd1, 8'hC0);
    set_hw(4'b1111);
    acc_valid = 1; acc_write = 0; acc_addr = 2'd0;
    #1 check("R4 status readback", rd_data, 8'h1F);
    step; idle; stop;
    check("R4 auto clear", flags, 5'b10000);
    check("R7 irq released", irq_n, 1);

    // R12 set wins over auto-clear
    set_hw(4'b1110);
    acc_valid = 1; acc_write = 0; acc_addr = 2'd0; step; idle;
    acc_stop = 1; alm_hit = 1; step; idle;
    check("R12 set wins", flags, 5'b10001);

    // R5 no auto-clear
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h00);
    set_hw(4'b0010);
    acc_valid = 1; acc_write = 0; acc_addr = 2'd0; step; idle; stop;
    check("R5 flags kept", flags[3:0], 4'b0010);

    // R7 level mode
    set_hw(4'b0001);
    check("R7 irq low", irq_n, 0);
    wr(2'd0, 8'h1E);
    check("R7 irq high after clear", irq_n, 1);

    // R6 pulse mode
    wr(2'd1, 8'h60);
    set_hw(4'b0001);
    check("R6 pulse start", irq_n, 0);
    give_ticks(100);
    set_hw(4'b0001);
    give_ticks(PT - 101);
    check("R6 still low before last tick", irq_n, 0);
    give_ticks(1);
    check("R6 pulse end not extended", irq_n, 1);

    summary;
  end
endmodule